// File: doc/BRIEF.md
# Pipelined Signed/Unsigned Integer Multiplier

This block multiplies two integer operands of independently chosen widths, A_W and B_W. Each operand is read as either two's complement or unsigned, as set by its own parameter. The full product is A_W + B_W bits wide. The block returns one contiguous bit range of that product, from OUT_HI down to OUT_LO.

When rounding is enabled, the discarded bits below OUT_LO are folded into the retained slice. Rounding is symmetric, so a value exactly halfway between two results moves away from zero.

Latency is exactly DEPTH clock cycles. DEPTH 0 gives a purely combinational path. DEPTH 1 registers only the result. Larger depths add one register on the operands and put the remaining stages after the arithmetic.

The clock enable and the synchronous clear each have a presence parameter. A further parameter decides which of the two wins when both are asserted.

Top module: `pipe_mult`

## Requirements
- R1: The product is computed at full width A_W+B_W. An operand whose signedness parameter is 1 is read as two's complement. An operand whose parameter is 0 is read as a non-negative value.
- R2: Output bit i equals bit OUT_LO+i of the (possibly rounded) full product. With OUT_LO=0 and OUT_HI=A_W+B_W-1, the output is the whole product.
- R3: With ROUND_EN=1 and OUT_LO>0, half a retained LSB (2^(OUT_LO-1)) is added to a non-negative product before the low bits are dropped. For a negative product, 2^(OUT_LO-1)-1 is added instead. The effect is that ties round away from zero.
- R4: The result of an operand pair appears at the output exactly DEPTH rising edges after the pair is applied. With DEPTH=0 it appears in the same cycle.
- R5: An edge with `sclr` high that is allowed to clear sets every pipeline register to zero. The output then reads 0 until new data has passed through the whole pipeline.
- R6: With PRI=PRI_CLEAR_WINS, `sclr` high clears every register even while `ce` is low.
- R7: With PRI=PRI_ENABLE_WINS, `sclr` has no effect while `ce` is low: the output holds its value.
- R8: With `ce` low and no clear in effect, every register holds, so the output stays constant while the operands change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| ce | input | 1 | Active-high clock enable for every register (ignored when USE_CE=0) |
| sclr | input | 1 | Active-high synchronous clear for every register (ignored when USE_CLR=0) |
| a | input | A_W | Operand A |
| b | input | B_W | Operand B |
| p | output | OUT_HI-OUT_LO+1 | Selected and optionally rounded slice of the product |

## Verification
A wrong sign extension or rounding increment shows as a wrong output value exactly DEPTH cycles after the operand pair that caused it. The first most-negative or all-ones operand already exposes it. A stage that ignores the enable or the clear shows within one edge as an output that changes when it should hold, or holds when it should clear. A miscounted pipeline shifts every result by whole cycles, so each comparison in a streamed sweep misses its pair. The sweeps cover every operand pair of three small configurations: mixed signed-by-unsigned with rounding, signed-by-signed combinational at full width, and unsigned with rounding and single-stage latency.

// File: rtl/pipe_mult_pkg.sv
package pipe_mult_pkg;

    // Which control wins when clear and enable disagree.
    typedef enum logic {
        PRI_CLEAR_WINS  = 1'b0,
        PRI_ENABLE_WINS = 1'b1
    } clr_pri_e;

    // Effective control seen by every pipeline stage.
    typedef struct packed {
        logic ce;
        logic clr;
    } ctl_t;

    function automatic logic stage_clears(ctl_t c, clr_pri_e pri);
        return c.clr && ((pri == PRI_CLEAR_WINS) || c.ce);
    endfunction

endpackage

// File: rtl/pipe_mult_delay.sv
module pipe_mult_delay
    import pipe_mult_pkg::*;
#(
    parameter int       W   = 8,
    parameter int       N   = 1,
    parameter clr_pri_e PRI = PRI_CLEAR_WINS
) (
    input  logic         clk,
    input  ctl_t         ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (N == 0) begin : g_pass
            logic unused_ctl;
            assign unused_ctl = ^{clk, ctl};
            assign dout = din;
        end else begin : g_regs
            logic [W-1:0] stg_d [N];
            logic [W-1:0] stg_q [N];
            logic         clear_d;
            logic         primed_q = 1'b0;

            always_comb begin
                clear_d = stage_clears(ctl, PRI);
                if (clear_d) begin
                    stg_d[0] = '0;
                end else if (ctl.ce) begin
                    stg_d[0] = din;
                end else begin
                    stg_d[0] = stg_q[0];
                end
                for (int i = 1; i < N; i++) begin
                    if (clear_d) begin
                        stg_d[i] = '0;
                    end else if (ctl.ce) begin
                        stg_d[i] = stg_q[i-1];
                    end else begin
                        stg_d[i] = stg_q[i];
                    end
                end
            end

            always_ff @(posedge clk) begin
                stg_q <= stg_d;
                if (ctl.clr) begin
                    primed_q <= 1'b1;
                end
            end

            assign dout = stg_q[N-1];

            // Value that should move into the last stage on an advancing edge.
            logic [W-1:0] tap;
            if (N == 1) begin : g_tap_in
                assign tap = din;
            end else begin : g_tap_stg
                assign tap = stg_q[N-2];
            end

            AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!primed_q)
                (ctl.clr && (ctl.ce || PRI == PRI_CLEAR_WINS)) |=> (dout == '0)); // R5
            AST_CLEAR_BEATS_HOLD: assert property (@(posedge clk) disable iff (!primed_q)
                (PRI == PRI_CLEAR_WINS && ctl.clr && !ctl.ce) |=> (dout == '0)); // R6
            AST_CLEAR_NEEDS_CE: assert property (@(posedge clk) disable iff (!primed_q)
                (PRI == PRI_ENABLE_WINS && ctl.clr && !ctl.ce) |=> $stable(dout)); // R7
            AST_HOLD_ON_IDLE: assert property (@(posedge clk) disable iff (!primed_q)
                (!ctl.ce && !ctl.clr) |=> $stable(dout)); // R8
            AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (!primed_q)
                (ctl.ce && !ctl.clr) |=> (dout == $past(tap))); // R4
        end
    endgenerate

endmodule

// File: rtl/pipe_mult_core.sv
module pipe_mult_core #(
    parameter int A_W      = 18,
    parameter int B_W      = 18,
    parameter bit A_SIGNED = 1'b1,
    parameter bit B_SIGNED = 1'b1,
    localparam int P_W     = A_W + B_W
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic [P_W-1:0] prod,
    output logic           neg
);

    // One guard bit above the full product keeps unsigned operands non-negative.
    localparam int EW = P_W + 1;

    logic signed [EW-1:0] ax;
    logic signed [EW-1:0] bx;
    logic signed [EW-1:0] px;
    logic                 unused_top;

    always_comb begin
        ax   = A_SIGNED ? {{(EW-A_W){a[A_W-1]}}, a} : {{(EW-A_W){1'b0}}, a};
        bx   = B_SIGNED ? {{(EW-B_W){b[B_W-1]}}, b} : {{(EW-B_W){1'b0}}, b};
        px   = ax * bx;
        prod = px[P_W-1:0];
        neg  = (A_SIGNED || B_SIGNED) ? px[P_W-1] : 1'b0;
    end

    assign unused_top = px[EW-1];

endmodule

// File: rtl/pipe_mult_round.sv
module pipe_mult_round #(
    parameter int P_W      = 36,
    parameter int OUT_HI   = 35,
    parameter int OUT_LO   = 0,
    parameter bit ROUND_EN = 1'b0,
    localparam int OW      = OUT_HI - OUT_LO + 1
) (
    input  logic [P_W-1:0] prod,
    input  logic           neg,
    output logic [OW-1:0]  res
);

    generate
        if (ROUND_EN && OUT_LO > 0) begin : g_rnd
            localparam logic [P_W:0] HALF    = (P_W+1)'(1) << (OUT_LO - 1);
            localparam logic [P_W:0] HALF_M1 = HALF - (P_W+1)'(1);

            logic [P_W:0] ext_d;
            logic [P_W:0] sum_d;
            logic         unused_sum;

            always_comb begin
                ext_d = {neg, prod};
                sum_d = ext_d + (neg ? HALF_M1 : HALF);
            end

            assign res        = sum_d[OUT_HI:OUT_LO];
            assign unused_sum = ^sum_d;
        end else begin : g_cut
            logic unused_cut;
            assign res        = prod[OUT_HI:OUT_LO];
            assign unused_cut = ^{prod, neg};
        end
    endgenerate

endmodule

// File: rtl/pipe_mult.sv
module pipe_mult
    import pipe_mult_pkg::*;
#(
    parameter int       A_W      = 18,
    parameter int       B_W      = 18,
    parameter bit       A_SIGNED = 1'b1,
    parameter bit       B_SIGNED = 1'b1,
    parameter int       OUT_HI   = 35,
    parameter int       OUT_LO   = 0,
    parameter bit       ROUND_EN = 1'b0,
    parameter int       DEPTH    = 1,
    parameter bit       USE_CE   = 1'b1,
    parameter bit       USE_CLR  = 1'b1,
    parameter clr_pri_e PRI      = PRI_CLEAR_WINS
) (
    input  logic                     clk,
    input  logic                     ce,
    input  logic                     sclr,
    input  logic [A_W-1:0]           a,
    input  logic [B_W-1:0]           b,
    output logic [OUT_HI-OUT_LO:0]   p
);

    localparam int P_W     = A_W + B_W;
    localparam int OW      = OUT_HI - OUT_LO + 1;
    localparam int IN_STG  = (DEPTH >= 2) ? 1 : 0;
    localparam int OUT_STG = DEPTH - IN_STG;

    ctl_t           ctl_d;
    logic [P_W-1:0] ops_q;
    logic [P_W-1:0] prod_d;
    logic           neg_d;
    logic [OW-1:0]  res_d;

    always_comb begin
        ctl_d.ce  = USE_CE  ? ce   : 1'b1;
        ctl_d.clr = USE_CLR ? sclr : 1'b0;
    end

    pipe_mult_delay #(.W(P_W), .N(IN_STG), .PRI(PRI)) u_in_stage (
        .clk  (clk),
        .ctl  (ctl_d),
        .din  ({a, b}),
        .dout (ops_q)
    );

    pipe_mult_core #(
        .A_W(A_W), .B_W(B_W), .A_SIGNED(A_SIGNED), .B_SIGNED(B_SIGNED)
    ) u_core (
        .a    (ops_q[P_W-1:B_W]),
        .b    (ops_q[B_W-1:0]),
        .prod (prod_d),
        .neg  (neg_d)
    );

    pipe_mult_round #(
        .P_W(P_W), .OUT_HI(OUT_HI), .OUT_LO(OUT_LO), .ROUND_EN(ROUND_EN)
    ) u_round (
        .prod (prod_d),
        .neg  (neg_d),
        .res  (res_d)
    );

    pipe_mult_delay #(.W(OW), .N(OUT_STG), .PRI(PRI)) u_out_stage (
        .clk  (clk),
        .ctl  (ctl_d),
        .din  (res_d),
        .dout (p)
    );

endmodule

// File: tb/pipe_mult_bench.sv
`timescale 1ns/1ps
module pipe_mult_bench;

    logic       clk = 1'b0;
    logic       ce;
    logic       sclr;
    logic [3:0] a_bus;
    logic [3:0] b_bus;
    logic [4:0] p_main;
    logic [5:0] p_b;
    logic [3:0] p_c;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    // 4-bit signed x 4-bit unsigned, bits [6:2] rounded, latency 3, clear wins.
    pipe_mult #(
        .A_W(4), .B_W(4), .A_SIGNED(1'b1), .B_SIGNED(1'b0),
        .OUT_HI(6), .OUT_LO(2), .ROUND_EN(1'b1), .DEPTH(3),
        .USE_CE(1'b1), .USE_CLR(1'b1), .PRI(pipe_mult_pkg::PRI_CLEAR_WINS)
    ) u_pipe_mult (
        .clk(clk), .ce(ce), .sclr(sclr), .a(a_bus), .b(b_bus), .p(p_main)
    );

    // 3-bit signed x 3-bit signed, full product, combinational.
    pipe_mult #(
        .A_W(3), .B_W(3), .A_SIGNED(1'b1), .B_SIGNED(1'b1),
        .OUT_HI(5), .OUT_LO(0), .ROUND_EN(1'b0), .DEPTH(0),
        .USE_CE(1'b0), .USE_CLR(1'b0), .PRI(pipe_mult_pkg::PRI_CLEAR_WINS)
    ) u_pipe_mult_b (
        .clk(clk), .ce(ce), .sclr(sclr), .a(a_bus[2:0]), .b(b_bus[2:0]), .p(p_b)
    );

    // 3-bit unsigned x 2-bit unsigned, bits [4:1] rounded, latency 1, enable wins.
    pipe_mult #(
        .A_W(3), .B_W(2), .A_SIGNED(1'b0), .B_SIGNED(1'b0),
        .OUT_HI(4), .OUT_LO(1), .ROUND_EN(1'b1), .DEPTH(1),
        .USE_CE(1'b1), .USE_CLR(1'b1), .PRI(pipe_mult_pkg::PRI_ENABLE_WINS)
    ) u_pipe_mult_c (
        .clk(clk), .ce(ce), .sclr(sclr), .a(a_bus[2:0]), .b(b_bus[1:0]), .p(p_c)
    );

    function automatic int ref_main(logic [3:0] x, logic [3:0] y);
        int pr;
        int r;
        pr = int'($signed(x)) * int'(y);
        r  = (pr >= 0) ? ((pr + 2) >>> 2) : ((pr + 1) >>> 2);
        return r & 31;
    endfunction

    function automatic int ref_b(logic [2:0] x, logic [2:0] y);
        return (int'($signed(x)) * int'($signed(y))) & 63;
    endfunction

    function automatic int ref_c(logic [2:0] x, logic [1:0] y);
        int pr;
        pr = int'(x) * int'(y);
        return ((pr + 1) >>> 1) & 15;
    endfunction

    task automatic check(string req, string what, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int hm0, hm1, hm2, hc0;
        hm0 = 0; hm1 = 0; hm2 = 0; hc0 = 0;
        ce = 1'b1; sclr = 1'b1; a_bus = 4'd0; b_bus = 4'd0;
        repeat (4) @(negedge clk);
        // R5: reset state after clear edges
        check("R5", "main after clear", int'(p_main), 0);
        check("R5", "c after clear", int'(p_c), 0);
        sclr = 1'b0;

        // Exhaustive streamed sweep: R1 R2 R3 on all pairs, R4 latency 3 and 1 and 0.
        for (int i = 0; i < 259; i++) begin
            @(negedge clk);
            if (i >= 3) check("R3", "main rounded slice at latency 3", int'(p_main), hm2);
            if (i >= 1) check("R4", "c rounded slice at latency 1", int'(p_c), hc0);
            hm2 = hm1;
            hm1 = hm0;
            a_bus = 4'(i % 256);
            b_bus = 4'((i % 256) >> 4);
            hm0 = ref_main(a_bus, b_bus);
            hc0 = ref_c(a_bus[2:0], b_bus[1:0]);
            #1;
            // R1 and R2: full signed product, combinational
            check("R1", "b full product", int'(p_b), ref_b(a_bus[2:0], b_bus[2:0]));
        end

        // Control sequence.
        @(negedge clk);
        a_bus = 4'd3; b_bus = 4'd5; ce = 1'b1; sclr = 1'b0;
        repeat (4) @(negedge clk);
        check("R3", "main 3*5", int'(p_main), 4);
        check("R2", "c 3*1", int'(p_c), 2);

        a_bus = 4'd7; b_bus = 4'd7; ce = 1'b0;
        repeat (3) @(negedge clk);
        check("R8", "main holds with ce low", int'(p_main), 4);
        check("R8", "c holds with ce low", int'(p_c), 2);

        sclr = 1'b1;
        @(negedge clk);
        check("R6", "main cleared with ce low", int'(p_main), 0);
        check("R7", "c ignores clear with ce low", int'(p_c), 2);

        ce = 1'b1;
        @(negedge clk);
        check("R5", "c cleared with ce high", int'(p_c), 0);

        sclr = 1'b0;
        @(negedge clk);
        check("R5", "main pipeline empty after clear", int'(p_main), 0);
        check("R4", "c 7*3 after one edge", int'(p_c), 11);
        repeat (2) @(negedge clk);
        check("R4", "main 7*7 after three edges", int'(p_main), 12);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule